// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Claim

This block gathers level interrupt requests from a set of sources and hands each one to a small group of targets, called contexts. Each source has a pending flag and a claimed flag. A source's level input sets its pending flag. Each context has its own enable mask and priority threshold. For every context, the block continuously works out which enabled, pending and unclaimed source has the highest priority above the threshold. It presents that source's ID and raises the matching interrupt line of a hart.

Software uses a word-wide register port to program the source priorities, the per-context enable masks and the thresholds. Reading a context's claim register returns the winning ID and takes ownership of that source. Writing the same ID back to that register releases it. The contexts come in pairs per hart: the even context of a pair drives the hart's machine-level line and the odd context drives the supervisor-level line.

Top module: `irq_arbiter`

## Requirements
- R1: A source can win for a context only while it is pending, not claimed, and enabled in that context's mask.
- R2: A source can win only when its priority is strictly greater than the context's threshold. Equal priority, or priority 0, never wins.
- R3: The highest priority wins. Among equal priorities the lowest ID wins. Each context reports its winner on `ctx_id_o[c*ID_W +: ID_W]`.
- R4: ID 0 means that no source qualifies. The input `src_i[0]` is never delivered, whatever its priority and enable settings.
- R5: The interrupt line of context c is high exactly when its reported ID is nonzero. Context 2h drives `irq_m_o[h]` and context 2h+1 drives `irq_s_o[h]`.
- R6: A high `src_i[i]` sets pending bit i at the clock edge, unless source i is claimed. The effect shows in the ID outputs after that edge.
- R7: A read of a context's claim register returns that context's winner on `rdata_o`, with `rvalid_o` high, after the access edge. If the winner is nonzero, the same edge clears its pending bit and sets its claimed bit. A claim that returns 0 changes nothing.
- R8: A claimed source stays out of arbitration for every context until it is completed. While it is claimed, its level input does not set pending again.
- R9: Writing an ID between 1 and N_SRC-1 to a claim register clears that source's claimed bit. Writing 0 or an ID of N_SRC or more is ignored.
- R10: Byte addresses, with word alignment required. Misaligned or unmapped accesses read 0 and write nothing.
  - Priority of source i is at 0x000+4*i, in bits [PRIO_W-1:0].
  - The enable word w of context c is at 0x400+4*(c*WORDS+w). Bit b of that word is source 32*w+b. Bits for IDs of N_SRC or more read 0.
  - The threshold of context c is at 0x800+8*c.
  - The claim register of context c is at 0x804+8*c.
- R11: After reset, all pending, claimed, enable, priority and threshold state is 0, all IDs are 0 and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt requests |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| irq_m_o | output | N_HART | Machine-level interrupt per hart |
| irq_s_o | output | N_HART | Supervisor-level interrupt per hart |
| ctx_id_o | output | N_CTX*ID_W | Current winning ID per context |

## Verification
The state registers update on the edge that samples a strobe or a source level, and the ID and interrupt outputs are combinational from that state. Every result is therefore due one edge after its stimulus. Read data is registered, so it is also due one edge after the read strobe. The bench drives inputs on the falling edge and samples at the next falling edge, which always falls after exactly one rising edge. In the one case that takes two edges, completing a source whose level is still high, the bench waits one extra falling edge before it expects the source to be pending again.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int ADDR_W = 12;
  localparam logic [1:0] RGN_PRIO = 2'd0;
  localparam logic [1:0] RGN_EN   = 2'd1;
  localparam logic [1:0] RGN_CTX  = 2'd2;

  function automatic logic [31:0] en_word_mask(int w, int n_src);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (w * 32 + b) < n_src;
    return m;
  endfunction
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int N_SRC = 40,
  parameter int ID_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             claim_vld_i,
  input  logic [ID_W-1:0]  claim_id_i,
  input  logic             done_vld_i,
  input  logic [ID_W-1:0]  done_id_i,
  output logic [N_SRC-1:0] pending_o,
  output logic [N_SRC-1:0] claimed_o
);
  logic [N_SRC-1:0] pend_q, clm_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic take, drop, arm;
    assign take = claim_vld_i && (claim_id_i == ID_W'(i));
    assign drop = done_vld_i && (done_id_i == ID_W'(i));
    // source 0 is reserved for "none"
    assign arm  = (i != 0) && src_i[i] && !clm_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= 1'b0;
        clm_q[i]  <= 1'b0;
      end else begin
        if (take)     pend_q[i] <= 1'b0;
        else if (arm) pend_q[i] <= 1'b1;
        if (take)      clm_q[i] <= 1'b1;
        else if (drop) clm_q[i] <= 1'b0;
      end
    end
  end

  assign pending_o = pend_q;
  assign claimed_o = clm_q;
endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
  parameter int N_SRC  = 40,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6
) (
  input  logic [N_SRC-1:0]             elig_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]            thr_i,
  output logic [ID_W-1:0]              id_o
);
  always_comb begin
    logic [PRIO_W-1:0] best_p;
    best_p = thr_i;
    id_o   = '0;
    // ascending scan, strict compare: ties keep the lower ID
    for (int i = 1; i < N_SRC; i++) begin
      if (elig_i[i] && (prio_i[i] > best_p)) begin
        best_p = prio_i[i];
        id_o   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int N_CTX  = 4,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 6,
  parameter int WORDS  = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [31:0]                      wdata_i,
  input  logic [N_CTX-1:0][ID_W-1:0]       ctx_id_i,
  output logic [N_SRC-1:0][PRIO_W-1:0]     prio_o,
  output logic [N_CTX-1:0][PRIO_W-1:0]     thr_o,
  output logic [N_CTX-1:0][N_SRC-1:0]      en_o,
  output logic                             claim_vld_o,
  output logic [ID_W-1:0]                  claim_id_o,
  output logic                             done_vld_o,
  output logic [ID_W-1:0]                  done_id_o,
  output logic [31:0]                      rdata_o,
  output logic                             rvalid_o
);
  localparam int EN_W = WORDS * 32;

  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [N_CTX-1:0][PRIO_W-1:0] thr_q;
  logic [N_CTX-1:0][EN_W-1:0]   en_q;
  logic [31:0]                  rdata_q, rd_val;
  logic                         rvalid_q;

  logic       aligned, hit_prio, hit_en, hit_ctx, rd, wr;
  logic [1:0] region;
  logic [7:0] widx;
  logic [6:0] cidx;
  logic       off_claim;
  int         en_c, en_w;

  assign region    = addr_i[11:10];
  assign widx      = addr_i[9:2];
  assign cidx      = addr_i[9:3];
  assign off_claim = addr_i[2];
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign hit_prio  = aligned && (region == RGN_PRIO) && (int'(widx) < N_SRC);
  assign hit_en    = aligned && (region == RGN_EN) && (int'(widx) < N_CTX * WORDS);
  assign hit_ctx   = aligned && (region == RGN_CTX) && (int'(cidx) < N_CTX);
  assign rd        = req_i && !we_i;
  assign wr        = req_i && we_i;
  assign en_c      = int'(widx) / WORDS;
  assign en_w      = int'(widx) % WORDS;

  // claim select and read mux
  always_comb begin
    claim_id_o = '0;
    rd_val     = '0;
    for (int c = 0; c < N_CTX; c++) begin
      if (int'(cidx) == c) claim_id_o = ctx_id_i[c];
    end
    if (hit_prio) begin
      for (int i = 0; i < N_SRC; i++)
        if (int'(widx) == i) rd_val = 32'(prio_q[i]);
    end else if (hit_en) begin
      for (int c = 0; c < N_CTX; c++)
        for (int w = 0; w < WORDS; w++)
          if (en_c == c && en_w == w) rd_val = en_q[c][w*32 +: 32];
    end else if (hit_ctx) begin
      if (off_claim) rd_val = 32'(claim_id_o);
      else begin
        for (int c = 0; c < N_CTX; c++)
          if (int'(cidx) == c) rd_val = 32'(thr_q[c]);
      end
    end
  end

  assign claim_vld_o = rd && hit_ctx && off_claim && (claim_id_o != '0);
  assign done_vld_o  = wr && hit_ctx && off_claim &&
                       (wdata_i != 32'd0) && (wdata_i < 32'(N_SRC));
  assign done_id_o   = wdata_i[ID_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= '0;
      thr_q    <= '0;
      en_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_val;
      if (wr && hit_prio) begin
        for (int i = 0; i < N_SRC; i++)
          if (int'(widx) == i) prio_q[i] <= wdata_i[PRIO_W-1:0];
      end
      if (wr && hit_en) begin
        for (int c = 0; c < N_CTX; c++)
          for (int w = 0; w < WORDS; w++)
            if (en_c == c && en_w == w)
              en_q[c][w*32 +: 32] <= wdata_i & en_word_mask(w, N_SRC);
      end
      if (wr && hit_ctx && !off_claim) begin
        for (int c = 0; c < N_CTX; c++)
          if (int'(cidx) == c) thr_q[c] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < N_CTX; c++) begin : g_en
    assign en_o[c] = en_q[c][N_SRC-1:0];
  end

  assign prio_o   = prio_q;
  assign thr_o    = thr_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_HART = 2,
  parameter int N_SRC  = 40,
  parameter int PRIO_W = 3,
  localparam int N_CTX = 2 * N_HART,
  localparam int ID_W  = $clog2(N_SRC),
  localparam int WORDS = (N_SRC + 31) / 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_SRC-1:0]      src_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [11:0]           addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic                  rvalid_o,
  output logic [N_HART-1:0]     irq_m_o,
  output logic [N_HART-1:0]     irq_s_o,
  output logic [N_CTX*ID_W-1:0] ctx_id_o
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_CTX-1:0][PRIO_W-1:0] thr;
  logic [N_CTX-1:0][N_SRC-1:0]  en;
  logic [N_CTX-1:0][ID_W-1:0]   win;
  logic [N_SRC-1:0]             pend_w, clm_w;
  logic                         claim_vld, done_vld;
  logic [ID_W-1:0]              claim_id, done_id;

  irq_regs #(
    .N_SRC(N_SRC), .N_CTX(N_CTX), .PRIO_W(PRIO_W), .ID_W(ID_W), .WORDS(WORDS)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ctx_id_i    (win),
    .prio_o      (prio),
    .thr_o       (thr),
    .en_o        (en),
    .claim_vld_o (claim_vld),
    .claim_id_o  (claim_id),
    .done_vld_o  (done_vld),
    .done_id_o   (done_id),
    .rdata_o, .rvalid_o
  );

  irq_src_state #(.N_SRC(N_SRC), .ID_W(ID_W)) u_src (
    .clk_i, .rst_ni, .src_i,
    .claim_vld_i (claim_vld),
    .claim_id_i  (claim_id),
    .done_vld_i  (done_vld),
    .done_id_i   (done_id),
    .pending_o   (pend_w),
    .claimed_o   (clm_w)
  );

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    irq_ctx_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .elig_i (pend_w & ~clm_w & en[c]),
      .prio_i (prio),
      .thr_i  (thr[c]),
      .id_o   (win[c])
    );
    assign ctx_id_o[c*ID_W +: ID_W] = win[c];
  end

  for (genvar h = 0; h < N_HART; h++) begin : g_hart
    assign irq_m_o[h] = |win[2*h];
    assign irq_s_o[h] = |win[2*h+1];
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_HART = 2,
  parameter int N_SRC  = 40,
  parameter int N_CTX  = 4,
  parameter int ID_W   = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [11:0]           addr_i,
  input logic [31:0]           rdata_o,
  input logic                  rvalid_o,
  input logic [N_HART-1:0]     irq_m_o,
  input logic [N_HART-1:0]     irq_s_o,
  input logic [N_CTX*ID_W-1:0] ctx_id_o,
  input logic [N_SRC-1:0]      pend_w,
  input logic [N_SRC-1:0]      clm_w
);
  logic            claim_rd;
  logic [ID_W-1:0] sel_id, last_id;
  logic            last_vld;

  assign claim_rd = req_i && !we_i && (addr_i[1:0] == 2'b00) &&
                    (addr_i[11:10] == 2'd2) && addr_i[2] &&
                    (int'(addr_i[9:3]) < N_CTX);

  always_comb begin
    sel_id = '0;
    for (int c = 0; c < N_CTX; c++)
      if (int'(addr_i[9:3]) == c) sel_id = ctx_id_o[c*ID_W +: ID_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vld <= 1'b0;
      last_id  <= '0;
    end else begin
      last_vld <= claim_rd;
      last_id  <= sel_id;
    end
  end

  AST_READ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R7
  AST_CLAIM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_vld |-> (rdata_o == 32'(last_id))); // R7
  AST_CLAIM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_vld && last_id != '0) |-> (clm_w[last_id] && !pend_w[last_id])); // R7
  AST_PEND_CLAIM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_w & clm_w) == '0); // R8
  AST_SRC0_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_w[0] && !clm_w[0]); // R4

  for (genvar c = 0; c < N_CTX; c++) begin : g_c
    logic [ID_W-1:0] id;
    logic            line;
    assign id   = ctx_id_o[c*ID_W +: ID_W];
    assign line = (c % 2 == 0) ? irq_m_o[c/2] : irq_s_o[c/2];
    AST_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id != '0) |-> (pend_w[id] && !clm_w[id])); // R1
    AST_LINE_MATCHES_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line == (id != '0)); // R5
  end
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .N_HART(N_HART), .N_SRC(N_SRC), .N_CTX(N_CTX), .ID_W(ID_W)
) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .rdata_o, .rvalid_o,
  .irq_m_o, .irq_s_o, .ctx_id_o, .pend_w, .clm_w
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  localparam int NH = 2, NS = 40, NC = 4, IW = 6, PW = 3, WD = 2;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0]     src = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [NH-1:0]     irq_m, irq_s;
  logic [NC*IW-1:0]  ctx_id;

  int nchk = 0, nerr = 0;
  bit done = 0;

  int       m_prio[NS];
  int       m_thr[NC];
  bit [63:0] m_en[NC];
  bit [NS-1:0] m_pend, m_clm;
  logic [31:0] rng = 32'h1badf00d;

  always #2 clk = ~clk;

  irq_arbiter #(.N_HART(NH), .N_SRC(NS), .PRIO_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_m_o(irq_m), .irq_s_o(irq_s), .ctx_id_o(ctx_id)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_win(int c);
    int best = 0, bp = m_thr[c];
    for (int i = 1; i < NS; i++)
      if (m_pend[i] && !m_clm[i] && m_en[c][i] && m_prio[i] > bp) begin
        best = i; bp = m_prio[i];
      end
    return best;
  endfunction

  task automatic check_all(string tag);
    for (int c = 0; c < NC; c++) begin
      int exp = ref_win(c);
      int line = (c % 2 == 0) ? int'(irq_m[c/2]) : int'(irq_s[c/2]);
      chk(tag, int'(ctx_id[c*IW +: IW]), exp);
      chk("R5 line", line, int'(exp != 0));
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); req = 1; we = 1; addr = 12'(a); wdata = 32'(d);
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); req = 1; we = 0; addr = 12'(a);
    @(negedge clk); req = 0; d = int'(rdata);
    chk("R7 rvalid", int'(rvalid), 1);
  endtask

  task automatic set_prio(int id, int p);
    wr(id * 4, p); m_prio[id] = p;
  endtask
  task automatic set_thr(int c, int t);
    wr(12'h800 + 8 * c, t); m_thr[c] = t;
  endtask
  task automatic set_en(int c, int w, bit [31:0] v);
    bit [31:0] mask = (w == 0) ? 32'hffffffff : 32'h000000ff;
    wr(12'h400 + 4 * (c * WD + w), int'(v));
    m_en[c][w*32 +: 32] = v & mask;
  endtask
  task automatic pulse(bit [NS-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk); src = '0;
    m_pend = m_pend | (v & ~m_clm);
    m_pend[0] = 1'b0;
  endtask
  task automatic claim(int c, string tag);
    int d, exp;
    exp = ref_win(c);
    rd(12'h804 + 8 * c, d);
    chk(tag, d, exp);
    if (exp != 0) begin m_pend[exp] = 0; m_clm[exp] = 1; end
  endtask
  task automatic complete(int c, int id);
    wr(12'h804 + 8 * c, id);
    if (id > 0 && id < NS) m_clm[id] = 0;
  endtask

  function automatic logic [31:0] nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int d;
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
    for (int c = 0; c < NC; c++) begin m_thr[c] = 0; m_en[c] = '0; end
    m_pend = '0; m_clm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check_all("R11 reset id");
    rd(12'h800, d); chk("R11 thr", d, 0);
    rd(12'h014, d); chk("R11 prio", d, 0);
    rd(12'h404, d); chk("R11 en", d, 0);

    // R10 map and readback
    set_prio(7, 5); rd(12'h01c, d); chk("R10 prio rb", d, 5);
    set_en(3, 1, 32'hffffffff); rd(12'h400 + 4 * 7, d); chk("R10 en mask", d, 255);
    set_thr(2, 6); rd(12'h810, d); chk("R10 thr rb", d, 6);
    rd(12'hc00, d); chk("R10 unmapped", d, 0);
    rd(12'h01d, d); chk("R10 misaligned", d, 0);
    wr(12'h01d, 1); rd(12'h01c, d); chk("R10 misaligned wr", d, 5);
    set_prio(7, 0); set_en(3, 1, 0); set_thr(2, 0);

    // R2 threshold sweep on source 5, ctx 0
    set_en(0, 0, 32'h20);
    pulse(40'h20); check_all("R6 pend set");
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        set_prio(5, p); set_thr(0, t);
        chk("R2 strict", int'(ctx_id[0 +: IW]), (p > t) ? 5 : 0);
      end
    set_thr(0, 0);

    // R4 source 0 never delivered
    set_en(1, 0, 32'h1); set_prio(0, 7); pulse(40'h1);
    check_all("R4 src0");
    chk("R4 src0 id", int'(ctx_id[IW +: IW]), 0);

    // R3 ordering
    set_en(2, 0, 32'hffffffff); set_en(2, 1, 32'hff);
    set_prio(3, 4); set_prio(9, 4); set_prio(33, 4);
    pulse(40'h02_0000_0208);
    check_all("R3 tie");
    chk("R3 tie low", int'(ctx_id[2*IW +: IW]), 5);
    set_prio(5, 0); chk("R3 tie low id", int'(ctx_id[2*IW +: IW]), 3);
    set_prio(33, 6); chk("R3 higher", int'(ctx_id[2*IW +: IW]), 33);
    set_prio(9, 6); chk("R3 tie 9", int'(ctx_id[2*IW +: IW]), 9);
    check_all("R3 mix");

    // R1 R3 R6 R7 R9 random sweep
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r = nxt();
      logic [31:0] s = nxt();
      case (r[2:0])
        3'd0, 3'd1: set_prio(int'(s[5:0]) % NS, int'(s[10:8]));
        3'd2: set_en(int'(s[1:0]), int'(s[2]), nxt());
        3'd3: set_thr(int'(s[1:0]), int'(s[6:4]) & 3);
        3'd4, 3'd5: pulse({s[7:0], nxt()});
        3'd6: claim(int'(s[1:0]), "R7 rand claim");
        default: complete(int'(s[1:0]), int'(s[5:0]));
      endcase
      check_all("R1/R3 rand");
    end

    // R8 R9 claim masking with held level
    for (int c = 0; c < NC; c++) set_thr(c, 0);
    for (int i = 1; i < NS; i++) complete(0, i);
    set_en(0, 0, 32'hffffffff); set_en(1, 0, 32'hffffffff);
    for (int n = 0; n < 45; n++) claim(0, "R7 drain");
    claim(0, "R7 empty");
    for (int i = 1; i < NS; i++) complete(0, i);
    for (int n = 0; n < 45; n++) claim(0, "R7 drain2");
    for (int n = 0; n < 45; n++) claim(1, "R7 drain3");
    set_prio(20, 7);
    for (int i = 1; i < NS; i++) complete(0, i);
    check_all("R8 idle");
    @(negedge clk); src[20] = 1'b1;
    @(negedge clk); m_pend[20] = 1;
    chk("R6 held", int'(ctx_id[0 +: IW]), 20);
    claim(0, "R7 claim20");
    repeat (4) @(negedge clk);
    chk("R8 masked c0", int'(ctx_id[0 +: IW]), 0);
    chk("R8 masked c1", int'(ctx_id[IW +: IW]), 0);
    check_all("R8 masked");
    complete(0, 0);
    @(negedge clk); check_all("R9 zero ignored");
    complete(0, 52);
    @(negedge clk); check_all("R9 range ignored");
    chk("R9 still claimed", int'(ctx_id[0 +: IW]), 0);
    complete(1, 20);
    chk("R9 not yet", int'(ctx_id[0 +: IW]), 0);
    @(negedge clk); m_pend[20] = 1;
    chk("R9 repend", int'(ctx_id[0 +: IW]), 20);
    check_all("R9 repend all");
    src = '0;
    claim(1, "R7 other ctx");
    check_all("R8 after");

    finish_run();
  end
endmodule